// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one channel of a memory-to-memory copy engine driven by a chain of descriptors in memory. Software first stores one or more descriptors in memory and loads the address of the first one into the pointer register. It then writes the control/status register with the enable and start bits both set. Each descriptor is four 32-bit words. The engine reads them over a shared memory port, copies the described words between a system-side address and a device-side address, and then follows the next pointer. It stops at the descriptor whose end flag is set.

When the chain finishes, the channel raises a sticky done bit, and the interrupt line follows that bit if the mode register allows it. An abort stops the channel without setting done and without an interrupt, so software polls the busy and enable bits to see that it has halted. While the channel is working, a read-only register shows the address of the descriptor it is processing. The register block decodes a fixed 16-byte window, selected by a channel index, so that several channels can share one address decoder.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, every register in the channel window reads 0, irq_o is low and mem_req_o is low.
- R2: A descriptor at address P is fetched as four reads at P, P+4, P+8 and P+12, in that order: system address, device address, byte count, next word.
- R3: Writing the CSR (offset 0x0) with bit0 (enable) and bit1 (start) both set while idle starts the chain at the pointer register. A start without the enable bit starts nothing.
- R4: MODE (offset 0x4) bit1 selects the direction. With 0 the engine reads from the system address and writes to the device address; with 1 it does the reverse. It moves count>>2 words, stepping both addresses by 4 after each word, and the low two count bits are ignored.
- R5: Bit0 of the next word is the end flag. When it is clear, the next descriptor is fetched at the next word with its low four bits forced to zero.
- R6: A descriptor whose word count is zero causes no data access; the engine goes straight on to its next pointer.
- R7: CSR bit3 (done) is set when the end descriptor completes and CSR bit4 (busy) clears at the same time. Done is cleared by writing 1 to it, and a write with bit3 at 0 leaves it unchanged.
- R8: irq_o equals done AND MODE bit0 (interrupt enable).
- R9: Writing CSR bit2 (abort) while busy halts the engine. No new read is issued, busy and enable read 0, done stays 0, irq_o stays low, and the memory port goes quiet.
- R10: The pointer register (offset 0x8) reads back as written. The current-descriptor register (offset 0xC) reads the address of the descriptor being processed, or the last one processed.
- R11: Start and abort read back as 0. A start while busy is ignored.
- R12: The channel decodes only addresses CHAN_IDX*16 to CHAN_IDX*16+15. Writes outside that window are ignored and reads outside it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Transfer-done interrupt, level |
| mem_req_o | output | 1 | Memory request, accepted in the cycle it is issued |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | DW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| mem_rvalid_i | input | 1 | Read data valid, one or more cycles after the read |

## Verification
The bench goes after the skipped zero-count descriptor. A design that got it wrong would run one read and write too many, or wrap its word counter and copy a huge block, and the access counts would show it. It checks that the next pointer has its flag and low bits masked, since a design that did not mask them would fetch misaligned descriptors and copy garbage. It checks that the low two bits of the byte count are ignored, because a design that rounded up would write one word past the end. An abort in the middle of a long copy must leave the last destination word intact, with done and irq low. A start issued while busy must leave the current descriptor unchanged, because a design that restarted would jump to the new pointer.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DRD, S_DWT, S_DECIDE, S_XRD, S_XWT, S_XWR, S_NEXT
  } seq_state_e;

  localparam int CSR_EN    = 0;
  localparam int CSR_START = 1;
  localparam int CSR_ABORT = 2;
  localparam int CSR_DONE  = 3;
  localparam int CSR_BUSY  = 4;

  localparam int MODE_IRQ = 0;
  localparam int MODE_DIR = 1;

  localparam logic [1:0] OFF_CSR  = 2'd0;
  localparam logic [1:0] OFF_MODE = 2'd1;
  localparam logic [1:0] OFF_PTR  = 2'd2;
  localparam logic [1:0] OFF_CUR  = 2'd3;
endpackage

// File: rtl/desc_dma_regs.sv
module desc_dma_regs
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DW       = 32,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              done_set_i,
  input  logic              halt_i,
  input  logic [DW-1:0]     cur_desc_i,
  output logic              start_o,
  output logic              abort_o,
  output logic [DW-1:0]     ptr_o,
  output logic              dir_o,
  output logic              irq_o
);
  localparam int CHAN_W = ADDR_W - 4;
  localparam logic [CHAN_W-1:0] CHAN_SEL = CHAN_W'(CHAN_IDX);

  logic          hit, csr_wr;
  logic [1:0]    sel;
  logic          en_q, done_q, irq_en_q, dir_q;
  logic [DW-1:0] ptr_q;
  logic          done_clr;

  assign hit      = (addr_i[ADDR_W-1:4] == CHAN_SEL);
  assign sel      = addr_i[3:2];
  assign csr_wr   = we_i && hit && (sel == OFF_CSR);
  assign done_clr = csr_wr && wdata_i[CSR_DONE];

  assign start_o = csr_wr && wdata_i[CSR_EN] && wdata_i[CSR_START] && !busy_i;
  assign abort_o = csr_wr && wdata_i[CSR_ABORT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      done_q   <= 1'b0;
      irq_en_q <= 1'b0;
      dir_q    <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (halt_i)      en_q <= 1'b0;
      else if (csr_wr) en_q <= wdata_i[CSR_EN];

      if (done_set_i)    done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;

      if (we_i && hit && sel == OFF_MODE) begin
        irq_en_q <= wdata_i[MODE_IRQ];
        dir_q    <= wdata_i[MODE_DIR];
      end
      if (we_i && hit && sel == OFF_PTR) ptr_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (sel)
        OFF_CSR: begin
          rdata_o[CSR_EN]   = en_q;
          rdata_o[CSR_DONE] = done_q;
          rdata_o[CSR_BUSY] = busy_i;
        end
        OFF_MODE: begin
          rdata_o[MODE_IRQ] = irq_en_q;
          rdata_o[MODE_DIR] = dir_q;
        end
        OFF_PTR: rdata_o = ptr_q;
        default: rdata_o = cur_desc_i;
      endcase
    end
  end

  assign ptr_o = ptr_q;
  assign dir_o = dir_q;
  assign irq_o = done_q && irq_en_q;

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !done_clr) |=> done_q);

  assert_abort_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !done_q && !done_set_i) |=> (!done_q && !en_q && !irq_o));
endmodule

// File: rtl/desc_dma_seq.sv
module desc_dma_seq
  import desc_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] ptr_i,
  input  logic          dir_i,
  output logic          busy_o,
  output logic          done_set_o,
  output logic          halt_o,
  output logic [DW-1:0] cur_desc_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rvalid_i
);
  localparam int CW = DW - 2;
  localparam logic [DW-1:0] STEP = DW'(4);

  seq_state_e    state_q;
  logic [1:0]    widx_q;
  logic [DW-1:0] cur_q, sys_q, dev_q, nxt_q, data_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q, abort_q;
  logic          at_chk;

  // abort is only honoured where no read is outstanding
  assign at_chk = (state_q == S_DRD) || (state_q == S_DECIDE) ||
                  (state_q == S_XRD) || (state_q == S_NEXT);
  assign halt_o     = abort_q && at_chk;
  assign done_set_o = (state_q == S_NEXT) && !abort_q && nxt_q[0];
  assign busy_o     = (state_q != S_IDLE);
  assign cur_desc_o = cur_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      S_DRD: begin
        mem_req_o  = !abort_q;
        mem_addr_o = cur_q + DW'({widx_q, 2'b00});
      end
      S_XRD: begin
        mem_req_o  = !abort_q;
        mem_addr_o = dir_q ? dev_q : sys_q;
      end
      S_XWR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dir_q ? sys_q : dev_q;
        mem_wdata_o = data_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      widx_q  <= '0;
      cur_q   <= '0;
      sys_q   <= '0;
      dev_q   <= '0;
      nxt_q   <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (abort_i && state_q != S_IDLE) abort_q <= 1'b1;
      case (state_q)
        S_IDLE: begin
          abort_q <= 1'b0;
          if (start_i) begin
            cur_q   <= {ptr_i[DW-1:4], 4'b0000};
            dir_q   <= dir_i;
            widx_q  <= '0;
            state_q <= S_DRD;
          end
        end
        S_DRD: begin
          if (abort_q) begin
            abort_q <= 1'b0;
            state_q <= S_IDLE;
          end else state_q <= S_DWT;
        end
        S_DWT: begin
          if (mem_rvalid_i) begin
            case (widx_q)
              2'd0:    sys_q <= mem_rdata_i;
              2'd1:    dev_q <= mem_rdata_i;
              2'd2:    cnt_q <= mem_rdata_i[DW-1:2];
              default: nxt_q <= mem_rdata_i;
            endcase
            if (widx_q == 2'd3) state_q <= S_DECIDE;
            else begin
              widx_q  <= widx_q + 2'd1;
              state_q <= S_DRD;
            end
          end
        end
        S_DECIDE: begin
          if (abort_q) begin
            abort_q <= 1'b0;
            state_q <= S_IDLE;
          end else if (cnt_q == '0) state_q <= S_NEXT;
          else state_q <= S_XRD;
        end
        S_XRD: begin
          if (abort_q) begin
            abort_q <= 1'b0;
            state_q <= S_IDLE;
          end else state_q <= S_XWT;
        end
        S_XWT: begin
          if (mem_rvalid_i) begin
            data_q  <= mem_rdata_i;
            state_q <= S_XWR;
          end
        end
        S_XWR: begin
          sys_q   <= sys_q + STEP;
          dev_q   <= dev_q + STEP;
          cnt_q   <= cnt_q - CW'(1);
          state_q <= (cnt_q == CW'(1)) ? S_NEXT : S_XRD;
        end
        S_NEXT: begin
          if (abort_q) begin
            abort_q <= 1'b0;
            state_q <= S_IDLE;
          end else if (nxt_q[0]) state_q <= S_IDLE;
          else begin
            cur_q   <= {nxt_q[DW-1:4], 4'b0000};
            widx_q  <= '0;
            state_q <= S_DRD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_zero_skip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_XRD) |-> (cnt_q != '0));

  assert_halt_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (!mem_req_o && !busy_o));

  assert_rvalid_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> (state_q == S_DWT || state_q == S_XWT));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !mem_req_o);
endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DW       = 32,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_rvalid_i
);
  logic          start, abort, busy, done_set, halt, dir;
  logic [DW-1:0] ptr, cur_desc;

  desc_dma_regs #(.ADDR_W(ADDR_W), .DW(DW), .CHAN_IDX(CHAN_IDX)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .done_set_i (done_set),
    .halt_i     (halt),
    .cur_desc_i (cur_desc),
    .start_o    (start),
    .abort_o    (abort),
    .ptr_o      (ptr),
    .dir_o      (dir),
    .irq_o      (irq_o)
  );

  desc_dma_seq #(.DW(DW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .abort_i      (abort),
    .ptr_i        (ptr),
    .dir_i        (dir),
    .busy_o       (busy),
    .done_set_o   (done_set),
    .halt_o       (halt),
    .cur_desc_o   (cur_desc),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_rvalid_i (mem_rvalid_i)
  );

  assert_irq_needs_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !irq_o) |=> !irq_o);
endmodule

// File: tb/desc_dma_chan_bench.sv
module desc_dma_chan_bench;
  localparam int CHAN = 2;
  localparam logic [7:0] BASE = 8'(CHAN * 16);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  logic [31:0] mem [256];
  logic [31:0] rd_log [16];
  int rd_cnt = 0;
  int wr_cnt = 0;
  int nlog = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  desc_dma_chan #(.ADDR_W(8), .DW(32), .CHAN_IDX(CHAN)) u_desc_dma_chan (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid)
  );

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata  <= mem[mem_addr[9:2]];
        mem_rvalid <= 1'b1;
        rd_cnt = rd_cnt + 1;
        if (nlog < 16) begin
          rd_log[nlog] = mem_addr;
          nlog = nlog + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = BASE + off; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_abs(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] v);
    reg_addr = BASE + off;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(8'h0, v);
      if (!v[4]) break;
    end
  endtask

  task automatic clr_counts();
    rd_cnt = 0; wr_cnt = 0; nlog = 0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input logic [31:0] n);
    mem[a/4] = s; mem[a/4+1] = d; mem[a/4+2] = c; mem[a/4+3] = n;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    for (int o = 0; o < 16; o += 4) begin
      rd(8'(o), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 no mem req", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_start_needs_en();
    logic [31:0] v;
    clr_counts();
    wr(8'h8, 32'h100);
    rd(8'h8, v);
    chk("R10 ptr readback", v, 32'h100);
    wr(8'h0, 32'h2);
    repeat (5) @(negedge clk);
    rd(8'h0, v);
    chk("R3 start w/o enable stays idle", v, 32'h0);
    chk("R3 no reads w/o enable", rd_cnt, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    put_desc(32'h100, 32'h200, 32'h300, 32'd16, 32'h1);
    for (int i = 0; i < 5; i++) begin
      mem[32'h200/4 + i] = 32'hA000 + i;
      mem[32'h300/4 + i] = 32'hDEAD;
    end
    clr_counts();
    wr(8'h4, 32'h0);
    wr(8'h0, 32'h3);
    rd(8'h0, v);
    chk("R3 busy after start", v & 32'h10, 32'h10);
    chk("R11 start reads 0", v & 32'h6, 32'h0);
    rd(8'hC, v);
    chk("R10 current descriptor", v, 32'h100);
    wait_idle();
    for (int i = 0; i < 4; i++) chk("R4 dir0 copy", mem[32'h300/4 + i], 32'hA000 + i);
    chk("R4 no overrun", mem[32'h300/4 + 4], 32'hDEAD);
    chk("R2 fetch word0", rd_log[0], 32'h100);
    chk("R2 fetch word1", rd_log[1], 32'h104);
    chk("R2 fetch word2", rd_log[2], 32'h108);
    chk("R2 fetch word3", rd_log[3], 32'h10C);
    chk("R2 data read after fetch", rd_log[4], 32'h200);
    chk("R4 write count", wr_cnt, 4);
    rd(8'h0, v);
    chk("R7 done set, busy clear", v, 32'h9);
    chk("R8 irq off when disabled", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_done_irq();
    logic [31:0] v;
    wr(8'h0, 32'h1);
    rd(8'h0, v);
    chk("R7 write 0 keeps done", v & 32'h8, 32'h8);
    wr(8'h4, 32'h1);
    chk("R8 irq follows done", {31'b0, irq}, 32'h1);
    wr(8'h0, 32'h9);
    rd(8'h0, v);
    chk("R7 W1C clears done", v & 32'h8, 32'h0);
    chk("R8 irq drops with done", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_chain_dir1();
    logic [31:0] v;
    put_desc(32'h140, 32'h240, 32'h340, 32'hB, 32'h18E);
    put_desc(32'h180, 32'h250, 32'h350, 32'h4, 32'h1);
    mem[32'h340/4] = 32'h11; mem[32'h344/4] = 32'h22; mem[32'h348/4] = 32'h33;
    mem[32'h350/4] = 32'h44;
    mem[32'h240/4] = 0; mem[32'h244/4] = 0; mem[32'h248/4] = 0; mem[32'h250/4] = 0;
    clr_counts();
    wr(8'h4, 32'h2);
    wr(8'h8, 32'h140);
    wr(8'h0, 32'h3);
    wait_idle();
    chk("R4 dir1 word0", mem[32'h240/4], 32'h11);
    chk("R4 dir1 word1", mem[32'h244/4], 32'h22);
    chk("R4 count low bits ignored", mem[32'h248/4], 32'h0);
    chk("R5 second descriptor copied", mem[32'h250/4], 32'h44);
    chk("R5 masked next fetch", rd_log[6], 32'h180);
    chk("R5 read count", rd_cnt, 11);
    rd(8'hC, v);
    chk("R10 last descriptor", v, 32'h180);
    wr(8'h0, 32'h9);
  endtask

  task automatic t_zero_skip();
    put_desc(32'h1C0, 32'h260, 32'h360, 32'h3, 32'h1D0);
    put_desc(32'h1D0, 32'h270, 32'h370, 32'h8, 32'h1);
    mem[32'h260/4] = 32'h55; mem[32'h360/4] = 32'hBEEF;
    mem[32'h270/4] = 32'h66; mem[32'h274/4] = 32'h77;
    clr_counts();
    wr(8'h4, 32'h0);
    wr(8'h8, 32'h1C0);
    wr(8'h0, 32'h3);
    wait_idle();
    chk("R6 zero descriptor untouched", mem[32'h360/4], 32'hBEEF);
    chk("R6 next copied w0", mem[32'h370/4], 32'h66);
    chk("R6 next copied w1", mem[32'h374/4], 32'h77);
    chk("R6 reads", rd_cnt, 10);
    chk("R6 writes", wr_cnt, 2);
    wr(8'h0, 32'h9);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int r0, w0;
    put_desc(32'h1E0, 32'h200, 32'h300, 32'd256, 32'h1);
    for (int i = 0; i < 64; i++) begin
      mem[32'h200/4 + i] = 32'h7000 + i;
      mem[32'h300/4 + i] = 32'hCAFE;
    end
    wr(8'h4, 32'h1);
    wr(8'h8, 32'h1E0);
    wr(8'h0, 32'h3);
    repeat (12) @(negedge clk);
    wr(8'h8, 32'h1C0);
    wr(8'h0, 32'h3);
    rd(8'hC, v);
    chk("R11 start while busy ignored", v, 32'h1E0);
    wr(8'h0, 32'h4);
    repeat (10) @(negedge clk);
    rd(8'h0, v);
    chk("R9 halted, en/done clear", v, 32'h0);
    chk("R9 no irq on abort", {31'b0, irq}, 32'h0);
    r0 = rd_cnt; w0 = wr_cnt;
    repeat (20) @(negedge clk);
    chk("R9 port quiet reads", rd_cnt, r0);
    chk("R9 port quiet writes", wr_cnt, w0);
    chk("R9 tail untouched", mem[32'h3FC/4], 32'hCAFE);
  endtask

  task automatic t_chan();
    logic [31:0] v;
    wr(8'h8, 32'h120);
    wr_abs(BASE + 8'h18, 32'h3F0);
    rd(8'h8, v);
    chk("R12 other window ignored", v, 32'h120);
    reg_addr = BASE + 8'h18;
    #1;
    chk("R12 other window reads 0", reg_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_needs_en();
    t_single();
    t_done_irq();
    t_chain_dir1();
    t_zero_skip();
    t_abort();
    t_chan();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule